// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column addresses of one SDRAM read or write burst, one column per clock. A burst starts when `load` is high. That cycle captures the starting column, the three-bit length code and the ordering bit. From the next cycle onward, `col_out` shows the current beat. Each cycle with `step` high moves to the following beat. The block raises `last_beat` while the final beat of a bounded burst is on `col_out`.

A burst ends in one of three ways:
- It runs to its natural end.
- `stop` ends it at once.
- A new `load` replaces it in any cycle, with a new starting column and a new configuration.

A full-page burst walks through all 256 columns and keeps wrapping. It never ends by itself.

The sequencer has two states. In `ST_IDLE` no burst is active. In `ST_RUN` a burst is active.

| Transition | Condition |
|---|---|
| `ST_IDLE` to `ST_RUN` | `load` |
| `ST_RUN` to `ST_RUN`, reload | `load` |
| `ST_RUN` to `ST_RUN`, next beat | `step` when not on the last beat |
| `ST_RUN` to `ST_IDLE`, stop | `stop` without `load` |
| `ST_RUN` to `ST_IDLE`, done | `step` on the last beat |

The priority is `load` first, then `stop`, then `step`.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, `col_valid`, `last_beat` and `mode_err` are 0.
- R2: The length codes give these burst lengths:
  - 3'b000 gives 1 beat.
  - 3'b001 gives 2 beats.
  - 3'b010 gives 4 beats.
  - 3'b011 gives 8 beats.
  - 3'b111 with `burst_interleave`=0 gives a full-page burst.
- R3: Sequential order (`burst_interleave`=0) works as follows. The column bits below the burst length equal the start's low bits plus the beat index, wrapping within that field. All higher bits stay at the start value.
- R4: Interleave order (`burst_interleave`=1): beat n shows `load_col` XOR n. The XOR is applied only to the bits below the burst length.
- R5: A full-page burst shows `load_col` + n modulo 256 on beat n. It never raises `last_beat` and stays active until `stop` or `load`.
- R6: `last_beat` is high exactly while the final beat of a bounded burst is shown. A `step` in that cycle makes `col_valid` drop in the next cycle.
- R7: `stop` without `load` makes `col_valid` 0 in the next cycle.
- R8: `load` in any state takes priority over `stop` and `step`. In the next cycle it shows beat 0, which is `load_col` itself.
- R9: Reserved length codes 3'b100, 3'b101 and 3'b110 run a one-beat burst and set `mode_err`.
- R10: Code 3'b111 with `burst_interleave`=1 is illegal. It runs a one-beat burst and sets `mode_err`.
- R11: While a burst is active and `step`, `stop` and `load` are all low, `col_out` and `col_valid` hold.
- R12: `mode_err` reflects the configuration of the most recent `load` and is unchanged by `stop` or by the burst ending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| burst_len_code | input | 3 | Length code, captured on `load` |
| burst_interleave | input | 1 | 0 selects sequential order, 1 selects interleave order; captured on `load` |
| load | input | 1 | Start or replace a burst |
| load_col | input | 8 | Starting column |
| step | input | 1 | Advance to the next beat |
| stop | input | 1 | Terminate the burst now |
| col_out | output | 8 | Current column |
| col_valid | output | 1 | A burst is active |
| last_beat | output | 1 | The final beat of a bounded burst is shown |
| mode_err | output | 1 | The last loaded configuration was reserved or illegal |

## Verification
Several control inputs can land in the same cycle.

`load` can coincide with `stop`, with `step`, or with a `step` on the last beat:
- A directed sequence drives a reload and a stop together mid-burst. The expected result is that the new burst starts at beat 0 rather than the sequencer going idle.
- A random stream also asserts all three inputs together.

`stop` can coincide with `step`. A random stream produces this case, and `stop` must win.

Every cycle is judged against a bench model that applies the stated priority, and `col_out` is compared with the column that model computes.

// File: rtl/burst_pkg.sv
package burst_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } burst_st_e;

    localparam logic [2:0] LEN_CODE_1    = 3'b000;
    localparam logic [2:0] LEN_CODE_2    = 3'b001;
    localparam logic [2:0] LEN_CODE_4    = 3'b010;
    localparam logic [2:0] LEN_CODE_8    = 3'b011;
    localparam logic [2:0] LEN_CODE_PAGE = 3'b111;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode #(
    parameter int COL_W = 8
) (
    input  logic [2:0]       len_code,
    input  logic             interleave,
    output logic [COL_W-1:0] len_mask,
    output logic             page_mode,
    output logic             cfg_err
);
    import burst_pkg::*;

    // len_mask = burst length - 1 (the bits that move inside the burst)
    always_comb begin
        len_mask  = '0;
        page_mode = 1'b0;
        cfg_err   = 1'b0;
        case (len_code)
            LEN_CODE_1: len_mask = '0;
            LEN_CODE_2: len_mask = COL_W'(1);
            LEN_CODE_4: len_mask = COL_W'(3);
            LEN_CODE_8: len_mask = COL_W'(7);
            LEN_CODE_PAGE: begin
                if (interleave) begin
                    cfg_err = 1'b1;          // R10: page length with XOR order
                end else begin
                    len_mask  = '1;
                    page_mode = 1'b1;
                end
            end
            default: cfg_err = 1'b1;         // R9: reserved code, single beat
        endcase
    end
endmodule

// File: rtl/burst_col_calc.sv
module burst_col_calc #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_col,
    input  logic [COL_W-1:0] beat_idx,
    input  logic [COL_W-1:0] len_mask,
    input  logic             interleave,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] seq_sum;

    always_comb begin
        seq_sum = base_col + beat_idx;
        if (interleave) begin
            col = base_col ^ (beat_idx & len_mask);
        end else begin
            // a full mask turns this into a plain modulo-2^COL_W increment
            col = (base_col & ~len_mask) | (seq_sum & len_mask);
        end
    end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       burst_len_code,
    input  logic             burst_interleave,
    input  logic             load,
    input  logic [COL_W-1:0] load_col,
    input  logic             step,
    input  logic             stop,
    output logic [COL_W-1:0] col_out,
    output logic             col_valid,
    output logic             last_beat,
    output logic             mode_err
);
    import burst_pkg::*;

    burst_st_e        state_q, state_d;
    logic [COL_W-1:0] base_q, beat_q, mask_q;
    logic             page_q, il_q, err_q;
    logic [COL_W-1:0] dec_mask;
    logic             dec_page, dec_err;
    logic             at_end;

    burst_len_decode #(.COL_W(COL_W)) u_dec (
        .len_code   (burst_len_code),
        .interleave (burst_interleave),
        .len_mask   (dec_mask),
        .page_mode  (dec_page),
        .cfg_err    (dec_err)
    );

    burst_col_calc #(.COL_W(COL_W)) u_calc (
        .base_col   (base_q),
        .beat_idx   (beat_q),
        .len_mask   (mask_q),
        .interleave (il_q),
        .col        (col_out)
    );

    assign at_end = (state_q == ST_RUN) && !page_q && (beat_q == mask_q);

    // next-state logic: load > stop > step
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load) state_d = ST_RUN;
            ST_RUN: begin
                if (load)                 state_d = ST_RUN;
                else if (stop)            state_d = ST_IDLE;
                else if (step && at_end)  state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
            mask_q <= '0;
            page_q <= 1'b0;
            il_q   <= 1'b0;
            err_q  <= 1'b0;
        end else if (load) begin
            base_q <= load_col;
            beat_q <= '0;
            mask_q <= dec_mask;
            page_q <= dec_page;
            il_q   <= burst_interleave;
            err_q  <= dec_err;
        end else if (state_q == ST_RUN && !stop && step && !at_end) begin
            beat_q <= beat_q + COL_W'(1);
        end
    end

    // outputs
    always_comb begin
        col_valid = (state_q == ST_RUN);
        last_beat = at_end;
        mode_err  = err_q;
    end

    a_r7_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !load) |=> !col_valid);

    a_r8_load_beat0: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (col_valid && col_out == $past(load_col)));

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !step && !stop && !load) |=> (col_valid && $stable(col_out)));

    a_r5_page_no_last: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && page_q) |-> !last_beat);

    a_r6_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && step && !load) |=> !col_valid);

    a_r3_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && step && !stop && !load && !last_beat && !il_q)
        |=> (((col_out ^ $past(col_out)) & ~mask_q) == '0));

    a_r12_err_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(mode_err));
endmodule

// File: tb/sdram_burst_colgen_bench.sv
module sdram_burst_colgen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] burst_len_code = '0;
    logic       burst_interleave = 1'b0;
    logic       load = 1'b0;
    logic [7:0] load_col = '0;
    logic       step = 1'b0;
    logic       stop = 1'b0;
    logic [7:0] col_out;
    logic       col_valid, last_beat, mode_err;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // bench model
    bit  m_valid = 1'b0;
    int  m_base = 0, m_beat = 0, m_code = 0;
    bit  m_il = 1'b0, m_err = 1'b0;

    always #5 clk = ~clk;

    sdram_burst_colgen u_sdram_burst_colgen (
        .clk(clk), .rst_n(rst_n), .burst_len_code(burst_len_code),
        .burst_interleave(burst_interleave), .load(load), .load_col(load_col),
        .step(step), .stop(stop), .col_out(col_out), .col_valid(col_valid),
        .last_beat(last_beat), .mode_err(mode_err)
    );

    // beats per burst; 0 means full page
    function automatic int exp_len(int code, bit il);
        case (code)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 8;
            7: return il ? 1 : 0;
            default: return 1;
        endcase
    endfunction

    function automatic bit exp_err(int code, bit il);
        return (code >= 4 && code <= 6) || (code == 7 && il);
    endfunction

    function automatic int exp_col(int base, int beat, int code, bit il);
        int n, mask;
        n = exp_len(code, il);
        if (n == 0) return (base + beat) & 255;
        mask = n - 1;
        if (il) return base ^ (beat & mask);
        return (base & ~mask & 255) | ((base + beat) & mask);
    endfunction

    task automatic chk(string tag, bit ok, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_outputs();
        int n;
        bit exp_last;
        chk("R7 col_valid", col_valid == m_valid, col_valid, m_valid);
        chk("R12 mode_err", mode_err == m_err, mode_err, m_err);
        n = exp_len(m_code, m_il);
        exp_last = m_valid && n != 0 && m_beat == n - 1;
        chk("R6 last_beat", last_beat == exp_last, last_beat, exp_last);
        if (m_valid) begin
            int e;
            e = exp_col(m_base, m_beat, m_code, m_il);
            if (n == 0)      chk("R5 col", col_out == e[7:0], col_out, e);
            else if (m_il)   chk("R4 col", col_out == e[7:0], col_out, e);
            else             chk("R3 col", col_out == e[7:0], col_out, e);
        end
    endtask

    task automatic cyc(bit ld, int col, int code, bit il, bit st, bit sp);
        int n;
        load = ld; load_col = col[7:0]; burst_len_code = code[2:0];
        burst_interleave = il; step = st; stop = sp;
        @(posedge clk);
        if (ld) begin
            m_valid = 1'b1; m_base = col & 255; m_beat = 0;
            m_code = code; m_il = il; m_err = exp_err(code, il);
        end else if (sp) begin
            m_valid = 1'b0;
        end else if (m_valid && st) begin
            n = exp_len(m_code, m_il);
            if (n != 0 && m_beat == n - 1) m_valid = 1'b0;
            else m_beat = (m_beat + 1) & 255;
        end
        #2;
        check_outputs();
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5eed);
        #23;
        chk("R1 col_valid", col_valid == 1'b0, col_valid, 0);
        chk("R1 last_beat", last_beat == 1'b0, last_beat, 0);
        chk("R1 mode_err", mode_err == 1'b0, mode_err, 0);
        rst_n = 1'b1;
        #5;
        // R3/R2: sequential length 8 from 0x3D wraps inside 0x38..0x3F
        cyc(1, 'h3D, 3, 0, 0, 0);
        for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 1, 0);
        // R4: interleave length 4 from 0x16
        cyc(1, 'h16, 2, 1, 0, 0);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1, 0);
        // R11: hold with no step
        cyc(1, 'h40, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 1, 0);
        // R5: full page from 0xFE wraps through 0, then stop (R7)
        cyc(1, 'hFE, 7, 0, 0, 0);
        for (int i = 0; i < 300; i++) cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 1, 1);
        // R9: reserved code, single beat, error flag
        cyc(1, 'h21, 5, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 0);
        // R10: page with interleave
        cyc(1, 'h77, 7, 1, 0, 0);
        cyc(0, 0, 0, 0, 1, 0);
        // R8: reload together with stop mid-burst
        cyc(1, 'h10, 3, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 0);
        cyc(1, 'hA5, 2, 1, 1, 1);
        cyc(0, 0, 0, 0, 1, 0);
        // random stream
        for (int i = 0; i < 6000; i++) begin
            bit ld, st, sp;
            ld = m_valid ? ($urandom % 12 == 0) : ($urandom % 3 == 0);
            st = ($urandom % 4) != 0;
            sp = ($urandom % 20) == 0;
            cyc(ld, $urandom % 256, $urandom % 8, $urandom % 2, st, sp);
        end
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #1500000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule